// File: doc/BRIEF.md
# Slow-Bus Clock Stretch Controller

This block sits between the processor's fast-cycle clock enable and the memory map. Every cycle it decodes the address the processor presents. An address outside the slow peripheral window completes in a single fast cycle. An address inside the window is stretched: the processor clock enable is held low until the access has occupied one whole period of the half-rate slow clock. A strobe marks that period for the slow peripheral.

The slow clock is given as `phase_i`, a free-running level that alternates on every fast cycle. Level 0 is the first half of a slow period and level 1 is the second half. An access that begins in the first half takes two fast cycles. An access that begins in the second half first waits one cycle for the next period to start, so it takes three. Each access is judged on its own. An instruction that makes several slow accesses in a row is therefore stretched once for each of them. Once a stretch has begun, the block pays no attention to the address until that stretch has completed.

Top module: `slow_bus_stretch`

## Requirements
- R1: After reset is released, with a fast address presented, `cpu_en_o` is 1 and `slow_stb_o` is 0.
- R2: An access to an address outside the slow window drives `cpu_en_o` high in the cycle it is presented, and `slow_stb_o` stays low.
- R3: The slow window is inclusive at both ends, from SLOW_LO (default 0xFC00) to SLOW_HI (default 0xFEFF). SLOW_LO-1 and SLOW_HI+1 are fast addresses.
- R4: A slow access that starts in a cycle with `phase_i`=0 holds `cpu_en_o` low for one cycle and raises it in the second cycle.
- R5: A slow access that starts in a cycle with `phase_i`=1 holds `cpu_en_o` low for two cycles and raises it in the third cycle.
- R6: For each slow access, `slow_stb_o` is high for exactly two consecutive cycles: first with `phase_i`=0, then with `phase_i`=1. `cpu_en_o` is high in the second of those cycles.
- R7: Slow accesses presented back to back are each stretched on their own. A slow address presented right after a completed access holds `cpu_en_o` low again.
- R8: Once a slow access has started, address changes have no effect until `cpu_en_o` has completed it.
- R9: A sequence of three fast accesses followed by three slow accesses, where the first slow access starts with `phase_i`=1, takes exactly 10 fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address presented by the processor |
| phase_i | input | 1 | Slow clock level: 0 is the first half, 1 is the second half |
| cpu_en_o | output | 1 | Processor clock enable; high completes the current access |
| slow_stb_o | output | 1 | Slow peripheral strobe covering one slow period |

## Verification
The hardest case to reach is a slow access that begins in the second half of a slow period and is followed at once by further slow accesses. In that case the wait cycle, the strobe pair and the completion cycle must all chain across differing parities. The bench controls parity directly: it inserts one fast cycle where needed, so that the next access starts on the phase it wants. It then steps access sequences by watching `cpu_en_o`. This reproduces the read-modify-write pattern in which six accesses take ten cycles. The same bench changes the address in the middle of a stretch to show that the address is ignored until the access completes.

// File: rtl/slow_bus_pkg.sv
package slow_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_LAST  = 2'd2
  } stretch_state_e;
endpackage

// File: rtl/slow_region_dec.sv
module slow_region_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOW_LO = 16'hFC00,
  parameter logic [ADDR_W-1:0] SLOW_HI = 16'hFEFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  always_comb hit_o = (addr_i >= SLOW_LO) && (addr_i <= SLOW_HI);
endmodule

// File: rtl/stretch_fsm.sv
module stretch_fsm
  import slow_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic phase_i,
  output logic cpu_en_o,
  output logic slow_stb_o
);
  stretch_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    cpu_en_o   = 1'b0;
    slow_stb_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!hit_i) begin
          cpu_en_o = 1'b1;
        end else if (phase_i) begin
          st_d = ST_FIRST;             // wait for the next slow period to open
        end else begin
          slow_stb_o = 1'b1;
          st_d       = ST_LAST;
        end
      end
      ST_FIRST: begin
        slow_stb_o = 1'b1;
        st_d       = ST_LAST;
      end
      ST_LAST: begin
        slow_stb_o = 1'b1;
        cpu_en_o   = 1'b1;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/slow_bus_stretch.sv
module slow_bus_stretch #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOW_LO = 16'hFC00,
  parameter logic [ADDR_W-1:0] SLOW_HI = 16'hFEFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              phase_i,
  output logic              cpu_en_o,
  output logic              slow_stb_o
);
  logic slow_hit;

  slow_region_dec #(
    .ADDR_W (ADDR_W),
    .SLOW_LO(SLOW_LO),
    .SLOW_HI(SLOW_HI)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (slow_hit)
  );

  stretch_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (slow_hit),
    .phase_i   (phase_i),
    .cpu_en_o  (cpu_en_o),
    .slow_stb_o(slow_stb_o)
  );
endmodule

// File: rtl/slow_bus_stretch_chk.sv
module slow_bus_stretch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic phase_i,
  input logic hit,
  input logic cpu_en_o,
  input logic slow_stb_o
);
  AST_FAST_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_en_o) && !hit |-> cpu_en_o && !slow_stb_o); // R2
  AST_EVEN_TWO_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_en_o) && hit && !phase_i |-> !cpu_en_o ##1 cpu_en_o); // R4
  AST_ODD_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_en_o && !slow_stb_o |=> slow_stb_o && !cpu_en_o); // R5
  AST_STB_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_stb_o) |-> !phase_i); // R6
  AST_STB_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_stb_o && !phase_i |=> slow_stb_o); // R6
  AST_STB_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_stb_o && phase_i |-> cpu_en_o); // R6
  AST_EACH_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_en_o) && hit |-> !cpu_en_o); // R7
endmodule

bind slow_bus_stretch slow_bus_stretch_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase_i   (phase_i),
  .hit       (slow_hit),
  .cpu_en_o  (cpu_en_o),
  .slow_stb_o(slow_stb_o)
);

// File: tb/slow_bus_stretch_test.sv
`timescale 1ns/1ps
module slow_bus_stretch_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = 16'h1000;
  logic        phase_i = 1'b0;
  logic        cpu_en_o, slow_stb_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit ph = 1'b0;
  int left = 0;        // model: cycles still owed by the access in progress
  bit acc_slow = 1'b0; // model: access in progress is slow
  bit en_seen;

  always #2.5 clk_i = ~clk_i;

  slow_bus_stretch uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .phase_i(phase_i), .cpu_en_o(cpu_en_o), .slow_stb_o(slow_stb_o)
  );

  function automatic bit in_window(logic [15:0] a);
    return (a >= 16'hFC00) && (a <= 16'hFEFF);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(logic [15:0] a, string tag);
    int  cur_left;
    bit  cur_slow;
    addr_i  = a;
    phase_i = ph;
    @(negedge clk_i);
    if (left == 0) begin
      cur_slow = in_window(a);
      cur_left = cur_slow ? (ph ? 3 : 2) : 1;
    end else begin
      cur_slow = acc_slow;
      cur_left = left;
    end
    check(cpu_en_o == (cur_left == 1), tag, "cpu_en", cpu_en_o, int'(cur_left == 1));
    check(slow_stb_o == (cur_slow && cur_left <= 2), tag, "slow_stb",
          slow_stb_o, int'(cur_slow && cur_left <= 2));
    en_seen = cpu_en_o;
    @(posedge clk_i);
    left     = cur_left - 1;
    acc_slow = cur_slow;
    ph       = ~ph;
    #1;
  endtask

  task automatic access(logic [15:0] a, string tag, output int cyc);
    cyc = 0;
    do begin
      tick(a, tag);
      cyc++;
    end while (!en_seen && cyc < 8);
  endtask

  task automatic align(bit want);
    if (ph != want) tick(16'h0200, "R2");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    int total;
    int idx;
    logic [15:0] seq [6];

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(cpu_en_o == 1'b1, "R1", "cpu_en after reset", cpu_en_o, 1);
    check(slow_stb_o == 1'b0, "R1", "slow_stb after reset", slow_stb_o, 0);
    @(posedge clk_i); #1;

    // R2: fast addresses, both parities
    tick(16'h0000, "R2"); tick(16'h1234, "R2"); tick(16'hFFFF, "R2"); tick(16'h8000, "R2");

    // R3: window edges
    access(16'hFBFF, "R3", cyc); check(cyc == 1, "R3", "cycles at LO-1", cyc, 1);
    access(16'hFF00, "R3", cyc); check(cyc == 1, "R3", "cycles at HI+1", cyc, 1);
    align(1'b0);
    access(16'hFC00, "R3", cyc); check(cyc == 2, "R3", "cycles at LO", cyc, 2);
    align(1'b0);
    access(16'hFEFF, "R3", cyc); check(cyc == 2, "R3", "cycles at HI", cyc, 2);

    // R4 / R5 / R6
    align(1'b0);
    access(16'hFE48, "R4", cyc); check(cyc == 2, "R4", "even start length", cyc, 2);
    align(1'b1);
    access(16'hFE48, "R5", cyc); check(cyc == 3, "R5", "odd start length", cyc, 3);
    align(1'b1);
    access(16'hFD10, "R6", cyc);

    // R7: back to back slow accesses
    align(1'b1);
    access(16'hFE40, "R7", cyc); check(cyc == 3, "R7", "first of chain", cyc, 3);
    access(16'hFE41, "R7", cyc); check(cyc == 2, "R7", "second of chain", cyc, 2);
    access(16'hFE42, "R7", cyc); check(cyc == 2, "R7", "third of chain", cyc, 2);

    // R8: address moves away mid-stretch
    align(1'b1);
    tick(16'hFE48, "R8");
    tick(16'h0010, "R8");
    check(en_seen == 1'b0, "R8", "still stretched", en_seen, 0);
    tick(16'h0020, "R8");
    check(en_seen == 1'b1, "R8", "completes on schedule", en_seen, 1);
    tick(16'h0030, "R8");

    // R9: three fast then three slow, first slow on phase 1
    seq = '{16'h0D2D, 16'h0D2E, 16'h0D2F, 16'hFE48, 16'hFE48, 16'hFE48};
    align(1'b0);
    total = 0;
    idx = 0;
    while (idx < 6 && total < 40) begin
      tick(seq[idx], "R9");
      total++;
      if (en_seen) idx++;
    end
    check(total == 10, "R9", "wall ticks for six accesses", total, 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule